// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

The controller gathers level-sensitive requests from 31 on-chip sources. Four of these are serial channels, and the other 27 are general sources. It holds a pending bit, an enable bit and an in-service bit for every source. It picks the highest-ranked source that is pending, enabled and not blocked by a source already in service. While such a source exists, it drives one request line to the processor, together with a programmable 3-bit level. During the single-cycle acknowledge strobe it returns an 8-bit vector: a 3-bit software base in the upper bits and the winner's 5-bit code in the lower bits.

Every source owns a 5-bit code from 31 (highest rank) down to 1. Code 0 is kept for the error vector. Four fixed code positions, called slots a to d, belong to the serial channels. Software chooses which channel answers in each slot. A spread bit moves the slots from four adjacent high codes to positions eight codes apart. One code can be promoted above every other code. Software reaches the four registers through a synchronous write port and a combinational read port.

Top module: `nvic_ctrl`

## Requirements
- R1: After reset, all four registers read zero, `irq_req` is low and `irq_lvl` is 0.
- R2: Register 0 (configuration) stores bits 23:0 of a write. Bits 30:24 read back as zero. The fields are: slot d selector in 23:22, slot c in 21:20, slot b in 19:18, slot a in 17:16, request level in 15:13, promoted code in 12:8, vector base in 7:5, and the spread bit in bit 0. The register changes only when software writes register 0.
- R3: Register 1 (pending) bit n sets in any cycle in which `src_req[n]` is high, and stays set. Writing 1 to bit n clears it. Writing 0 has no effect.
- R4: Register 2 (enable) is read/write. A 1 in bit n allows pending source n to request. A pending source whose enable bit is 0 does not raise `irq_req`.
- R5: `irq_req` is high whenever an eligible source exists. At the same time, `irq_lvl` equals configuration bits 15:13. Otherwise `irq_lvl` is 0.
- R6: While `iack` is high, `vec_o` = {configuration bits 7:5, winning code}. At all other times `vec_o` is 0. With slots a..d selecting channels 1..4 and base 101, channel 1 (`src_req[0]`) yields 0xBE.
- R7: Input bits 0..3 are serial channels 1..4, and bits 4..30 are general sources. With spread = 0, the slots sit at codes a=30, b=29, c=28, d=27. General sources take the remaining codes in descending order: source 4 has code 31, and source n (n = 5..30) has code 31-n. A larger code wins.
- R8: A slot selector value v (00..11) makes channel v+1 (input bit v) answer at that slot's code.
- R9: With spread = 1, the slots sit at codes a=30, b=22, c=14, d=6. General sources fill the other codes in descending order, starting with source 4 at code 31.
- R10: A nonzero promoted code ranks its source above all other sources. A promoted code of 0 changes nothing.
- R11: At `iack`, the winner's bit in register 3 (in-service) sets. Writing 1 to a bit of register 3 clears it. A pending, enabled source is eligible only if it outranks every source in service.
- R12: An `iack` with no eligible source returns the error vector {base, 00000} and leaves register 3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 31 | Level requests; bits 0..3 are serial channels 1..4 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 config, 1 pending, 2 enable, 3 in-service |
| wdata | input | 31 | Write data |
| rdata | output | 31 | Read data for the register selected by `addr` |
| irq_req | output | 1 | Request to the processor |
| irq_lvl | output | 3 | Request level while `irq_req` is high, else 0 |
| iack | input | 1 | Interrupt-acknowledge strobe |
| vec_o | output | 8 | Vector, driven only while `iack` is high |

## Verification
The assertions check on every cycle the rules that do not depend on the code map. A pending bit never clears without a write. The in-service set changes only on a write or an acknowledge. A granted acknowledge adds exactly one in-service bit. A refused acknowledge returns code 0. The configuration holds between writes. The rank order needs the bench's scenarios to show it: which code each channel lands on under both slot layouts, the effect of the promoted code, and the blocking and release of nested sources.

// File: rtl/nvic_pkg.sv
package nvic_pkg;
   localparam int CODE_W  = 5;
   localparam int NSER    = 4;
   localparam int NSRC    = (1 << CODE_W) - 1;
   localparam int CFG_W   = 24;
   localparam int LVL_W   = 3;
   localparam int BASE_W  = 3;
   localparam int SEL_W   = $clog2(NSER);
   // configuration field positions (decoded by neighbouring logic)
   localparam int F_SLOT  = 16;
   localparam int F_LVL   = 13;
   localparam int F_HP    = 8;
   localparam int F_BASE  = 5;
   localparam int F_SPRD  = 0;
   typedef logic [CODE_W-1:0] code_t;
   typedef logic [NSRC-1:0]   srcvec_t;
endpackage

// File: rtl/nvic_slotmap.sv
module nvic_slotmap #(
   parameter int CODE_W = 5,
   parameter int NSER   = 4,
   parameter int GAP    = 8
) (
   input  logic [NSER*$clog2(NSER)-1:0]             slot_sel,
   input  logic                                     spread,
   output logic [(1<<CODE_W)-1:1][CODE_W-1:0]       line_of_code
);
   localparam int NSRC  = (1 << CODE_W) - 1;
   localparam int SEL_W = $clog2(NSER);
   localparam int TOP   = NSRC - 1;

   if (TOP - GAP*(NSER-1) < 1) begin : g_bad_gap
      $error("spread gap pushes a slot below code 1");
   end
   if (GAP <= 1) begin : g_bad_gap2
      $error("spread gap must exceed 1");
   end

   logic [NSER-1:0][CODE_W-1:0] pos;

   for (genvar k = 0; k < NSER; k++) begin : g_pos
      localparam int P_TIGHT  = TOP - k;
      localparam int P_SPREAD = TOP - GAP*k;
      assign pos[k] = spread ? CODE_W'(P_SPREAD) : CODE_W'(P_TIGHT);
   end

   always_comb begin
      int  g;
      logic hit;
      g = NSER;
      line_of_code = '0;
      for (int c = NSRC; c >= 1; c--) begin
         hit = 1'b0;
         for (int k = 0; k < NSER; k++) begin
            if (pos[k] == CODE_W'(c)) begin
               hit = 1'b1;
               line_of_code[c] = CODE_W'(slot_sel[k*SEL_W +: SEL_W]);
            end
         end
         if (!hit) begin
            line_of_code[c] = CODE_W'(g);
            g = g + 1;
         end
      end
   end
endmodule

// File: rtl/nvic_arb.sv
module nvic_arb #(
   parameter int CODE_W = 5
) (
   input  logic [(1<<CODE_W)-1:1][CODE_W-1:0] line_of_code,
   input  logic [(1<<CODE_W)-2:0]             pend,
   input  logic [(1<<CODE_W)-2:0]             enab,
   input  logic [(1<<CODE_W)-2:0]             insvc,
   input  logic [CODE_W-1:0]                  promo,
   output logic                               any,
   output logic [CODE_W-1:0]                  win_code,
   output logic [CODE_W-1:0]                  win_line
);
   localparam int NSRC = (1 << CODE_W) - 1;
   localparam int RK_W = CODE_W + 1;

   logic [RK_W-1:0]   best_rk, busy_rk, rk;
   logic [CODE_W-1:0] best_c, best_l, ln;

   always_comb begin
      best_rk = '0;
      busy_rk = '0;
      best_c  = '0;
      best_l  = '0;
      for (int c = 1; c <= NSRC; c++) begin
         ln = line_of_code[c];
         rk = (CODE_W'(c) == promo) ? RK_W'(NSRC + 1) : RK_W'(c);
         if (pend[ln] && enab[ln] && rk > best_rk) begin
            best_rk = rk;
            best_c  = CODE_W'(c);
            best_l  = ln;
         end
         if (insvc[ln] && rk > busy_rk) busy_rk = rk;
      end
      any      = best_rk > busy_rk;
      win_code = any ? best_c : '0;
      win_line = best_l;
   end
endmodule

// File: rtl/nvic_ctrl.sv
module nvic_ctrl
   import nvic_pkg::*;
#(
   parameter int GAP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_req,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [NSRC-1:0]   wdata,
   output logic [NSRC-1:0]   rdata,
   output logic              irq_req,
   output logic [LVL_W-1:0]  irq_lvl,
   input  logic              iack,
   output logic [7:0]        vec_o
);
   if (NSRC < CFG_W) begin : g_bad_w
      $error("data path narrower than configuration");
   end
   if (BASE_W + CODE_W != 8) begin : g_bad_vec
      $error("vector must be 8 bits");
   end

   logic [CFG_W-1:0] cfg_q;
   srcvec_t          pend_q, enab_q, isr_q, ack_set;
   logic [(1<<CODE_W)-1:1][CODE_W-1:0] map;
   logic             any;
   code_t            win_code, win_line;

   wire wr_cfg  = wr_en && addr == 2'd0;
   wire wr_pend = wr_en && addr == 2'd1;
   wire wr_enab = wr_en && addr == 2'd2;
   wire wr_isr  = wr_en && addr == 2'd3;

   nvic_slotmap #(.CODE_W(CODE_W), .NSER(NSER), .GAP(GAP)) u_map (
      .slot_sel     (cfg_q[F_SLOT +: NSER*SEL_W]),
      .spread       (cfg_q[F_SPRD]),
      .line_of_code (map)
   );

   nvic_arb #(.CODE_W(CODE_W)) u_arb (
      .line_of_code (map),
      .pend         (pend_q),
      .enab         (enab_q),
      .insvc        (isr_q),
      .promo        (cfg_q[F_HP +: CODE_W]),
      .any          (any),
      .win_code     (win_code),
      .win_line     (win_line)
   );

   always_comb begin
      ack_set = '0;
      if (iack && any) ack_set[win_line] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         pend_q <= '0;
         enab_q <= '0;
         isr_q  <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= wdata[CFG_W-1:0];
         if (wr_enab) enab_q <= wdata;
         pend_q <= (pend_q & ~(wr_pend ? wdata : '0)) | src_req;
         isr_q  <= (isr_q  & ~(wr_isr  ? wdata : '0)) | ack_set;
      end
   end

   always_comb begin
      unique case (addr)
         2'd0:    rdata = NSRC'(cfg_q);
         2'd1:    rdata = pend_q;
         2'd2:    rdata = enab_q;
         default: rdata = isr_q;
      endcase
   end

   assign irq_req = any;
   assign irq_lvl = any ? cfg_q[F_LVL +: LVL_W] : '0;
   assign vec_o   = iack ? {cfg_q[F_BASE +: BASE_W], win_code} : 8'h00;
endmodule

// File: rtl/nvic_chk.sv
module nvic_chk
   import nvic_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic             iack,
   input logic             irq_req,
   input logic [7:0]       vec_o,
   input logic [NSRC-1:0]  pend_q,
   input logic [NSRC-1:0]  isr_q,
   input logic [CFG_W-1:0] cfg_q
);
   assert_err_vec_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && !irq_req) |-> vec_o[CODE_W-1:0] == '0);

   assert_isr_grow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && irq_req && !wr_en) |=> $countones(isr_q) == $countones($past(isr_q)) + 1);

   assert_isr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !iack) |=> $stable(isr_q));

   assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 2'd0) |=> $stable(cfg_q));
endmodule

bind nvic_ctrl nvic_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .iack    (iack),
   .irq_req (irq_req),
   .vec_o   (vec_o),
   .pend_q  (pend_q),
   .isr_q   (isr_q),
   .cfg_q   (cfg_q)
);

// File: tb/sim_nvic_ctrl.sv
`timescale 1ns/1ps
module sim_nvic_ctrl;
   localparam int N = 31;
   logic clk = 0, rst_n = 0, wr_en = 0, iack = 0;
   logic [N-1:0] src_req = '0, wdata = '0, rdata;
   logic [1:0] addr = '0;
   logic irq_req;
   logic [2:0] irq_lvl;
   logic [7:0] vec_o;
   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   nvic_ctrl u0 (.clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_req(irq_req),
      .irq_lvl(irq_lvl), .iack(iack), .vec_o(vec_o));

   // slots a..d = channels 1..4
   localparam logic [7:0] SLOTS_STD = 8'hE4;

   function automatic logic [N-1:0] cfgw(logic [7:0] sl, logic [2:0] lvl,
                                         logic [4:0] hp, logic [2:0] base, logic sp);
      return N'({sl, lvl, hp, base, 4'b0000, sp});
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [N-1:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0; wdata = '0;
   endtask

   task automatic rd(logic [1:0] a, output logic [N-1:0] d);
      @(negedge clk); addr = a; #2 d = rdata;
   endtask

   task automatic raise(logic [N-1:0] m);
      @(negedge clk); src_req = m;
      @(negedge clk); src_req = '0;
   endtask

   task automatic ack(output logic [7:0] v);
      @(negedge clk); iack = 1; #2 v = vec_o;
      @(negedge clk); iack = 0;
   endtask

   task automatic clean();
      wr(2'd1, '1); wr(2'd3, '1);
   endtask

   task automatic t_reset();
      logic [N-1:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d); chk("R1 reg", 32'(d), 0);
      end
      chk("R1 irq_req", 32'(irq_req), 0);
      chk("R1 irq_lvl", 32'(irq_lvl), 0);
   endtask

   task automatic t_cfg();
      logic [N-1:0] d;
      wr(2'd0, '1); rd(2'd0, d); chk("R2 width", 32'(d), 32'h00FF_FFFF);
      wr(2'd0, cfgw(SLOTS_STD, 3'd5, 5'd0, 3'b101, 1'b0));
      rd(2'd0, d); chk("R2 readback", 32'(d), 32'h00E4_A0A0);
   endtask

   task automatic t_pend_enable();
      logic [N-1:0] d;
      raise(N'(1) << 10);
      rd(2'd1, d); chk("R3 set", 32'(d), 32'h400);
      chk("R4 disabled no req", 32'(irq_req), 0);
      wr(2'd1, '0); rd(2'd1, d); chk("R3 write0 ignored", 32'(d), 32'h400);
      wr(2'd2, '1); #2;
      chk("R4 enabled req", 32'(irq_req), 1);
      chk("R5 level", 32'(irq_lvl), 5);
      wr(2'd1, N'(1) << 10); rd(2'd1, d); chk("R3 w1c", 32'(d), 0);
      chk("R5 idle level", 32'(irq_lvl), 0);
   endtask

   task automatic t_vector();
      logic [7:0] v; logic [N-1:0] d;
      chk("R6 idle vec", 32'(vec_o), 0);
      raise(N'(1));
      ack(v); chk("R6 channel1 vector", 32'(v), 32'hBE);
      rd(2'd3, d); chk("R11 isr set", 32'(d), 1);
      chk("R6 vec after ack", 32'(vec_o), 0);
      clean();
   endtask

   task automatic t_order();
      logic [7:0] v;
      raise((N'(1) << 4) | N'(1));
      ack(v); chk("R7 source4 top", 32'(v[4:0]), 31);
      clean();
      raise((N'(1) << 5) | (N'(1) << 30));
      ack(v); chk("R7 source5 code26", 32'(v[4:0]), 26);
      clean();
      raise(N'(1) << 30);
      ack(v); chk("R7 source30 code1", 32'(v[4:0]), 1);
      clean();
   endtask

   task automatic t_slots();
      logic [7:0] v;
      wr(2'd0, cfgw(8'h1B, 3'd5, 5'd0, 3'b101, 1'b0));
      raise(N'(1) | (N'(1) << 2));
      ack(v); chk("R8 ch3 in slot b", 32'(v[4:0]), 29);
      clean();
      raise(N'(1) << 3);
      ack(v); chk("R8 ch4 in slot a", 32'(v[4:0]), 30);
      clean();
   endtask

   task automatic t_spread();
      logic [7:0] v;
      wr(2'd0, cfgw(SLOTS_STD, 3'd5, 5'd0, 3'b101, 1'b1));
      raise((N'(1) << 1) | (N'(1) << 12));
      ack(v); chk("R9 slot b code22", 32'(v[4:0]), 22);
      clean();
      raise((N'(1) << 1) | (N'(1) << 11));
      ack(v); chk("R9 source11 code23", 32'(v[4:0]), 23);
      clean();
      raise((N'(1) << 3) | (N'(1) << 26));
      ack(v); chk("R9 slot d code6", 32'(v[4:0]), 6);
      clean();
   endtask

   task automatic t_promote();
      logic [7:0] v;
      wr(2'd0, cfgw(SLOTS_STD, 3'd5, 5'd5, 3'b101, 1'b0));
      raise((N'(1) << 26) | (N'(1) << 4));
      ack(v); chk("R10 promoted code5", 32'(v[4:0]), 5);
      clean();
      wr(2'd0, cfgw(SLOTS_STD, 3'd5, 5'd0, 3'b101, 1'b0));
   endtask

   task automatic t_nest();
      logic [7:0] v; logic [N-1:0] d;
      raise(N'(1) << 20);
      ack(v); chk("R11 first code11", 32'(v[4:0]), 11);
      chk("R11 self blocked", 32'(irq_req), 0);
      raise(N'(1) << 10); #2;
      chk("R11 higher passes", 32'(irq_req), 1);
      ack(v); chk("R11 nested code21", 32'(v[4:0]), 21);
      wr(2'd1, '1);
      raise(N'(1) << 25); #2;
      chk("R11 lower blocked", 32'(irq_req), 0);
      wr(2'd3, N'(1) << 10); #2;
      chk("R11 still blocked", 32'(irq_req), 0);
      rd(2'd3, d); chk("R11 isr w1c", 32'(d), 32'h0010_0000);
      wr(2'd3, N'(1) << 20); #2;
      chk("R11 released", 32'(irq_req), 1);
      clean();
   endtask

   task automatic t_error();
      logic [7:0] v; logic [N-1:0] d;
      ack(v); chk("R12 error vector", 32'(v), 32'hA0);
      rd(2'd3, d); chk("R12 isr unchanged", 32'(d), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_cfg();
      t_pend_enable();
      t_vector();
      t_order();
      t_slots();
      wr(2'd0, cfgw(SLOTS_STD, 3'd5, 5'd0, 3'b101, 1'b0));
      t_spread();
      wr(2'd0, cfgw(SLOTS_STD, 3'd5, 5'd0, 3'b101, 1'b0));
      t_promote();
      t_nest();
      t_error();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule